// File: doc/BRIEF.md
# Scan Pattern Generator with Phase Shifter

This block supplies pseudo-random stimulus for a scan-based self-test. A maximal-length linear feedback shift register moves one step on each test clock where the advance input is high. Its state then passes through an XOR network that gives every scan-chain input its own mix of register bits. Without this network, adjacent channels would carry copies of each other, one cycle apart. Each scan chain's serial input is driven by one channel bit during test, in place of vectors applied from outside.

When there are more channels than register bits, every register bit is used by several channels. Each channel's XOR tap set comes from a packed parameter. A zero slice in that parameter selects a built-in default pair of taps. A bypass input sends the raw register bits straight to the channels, so fault coverage can be compared with and without the shifter. The raw state is also an output. A synchronous reset loads the seed. A seed of zero is replaced by the value 1, so the register never starts in its dead state.

Top module: `scan_pattern_gen`

## Requirements
- R1: A clock edge with `rst` high loads the seed into `lfsrState`. If the seed parameter, truncated to `WIDTH` bits, is zero, the value 1 is loaded instead.
- R2: On an edge with `rst` low and `advance` high, the state shifts one place toward the MSB. The new bit 0 is the XOR of the state bits selected by the feedback mask. For a 16-bit register the mask selects bits 15, 14, 12 and 3. For an 8-bit register it selects bits 7, 5, 4 and 3.
- R3: On an edge with `rst` low and `advance` low, the state does not change.
- R4: Once reset has been applied, `lfsrState` is never all zeros.
- R5: Starting from the seed, the state first comes back to the seed after exactly 2^WIDTH - 1 advances.
- R6: With `bypass` low, a channel c whose tap slice is zero outputs state[b] XOR state[(b + 1 + g) mod WIDTH], where b = c mod WIDTH and g = c div WIDTH.
- R7: With `bypass` low, a channel c whose slice `TAP_SETS[c*WIDTH +: WIDTH]` is nonzero outputs the XOR of the state bits set in that slice.
- R8: With `bypass` high, channel c outputs state[c mod WIDTH].
- R9: With the default tap sets and `bypass` low, no two channels give the same bit stream.
- R10: `rst` takes priority over `advance`: the seed is loaded even when both are high.
- R11: `bypass` only changes the channel outputs and has no effect on how the state advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous reset; loads the seed |
| advance | input | 1 | Step enable for the register |
| bypass | input | 1 | High: channels carry raw register bits |
| chanOut | output | CHANNELS | One pattern bit per scan-chain input |
| lfsrState | output | WIDTH | Current register state |

## Verification
The main instance uses a 16-bit register feeding 24 channels. This is enough to run the full 65,535-step period and to show bits being reused with two different default tap spacings. A second instance uses an 8-bit register, a zero seed, 10 channels and one overridden tap slice. With it, the zero-seed substitution, the 255-step period and a custom three-bit tap set can all be checked. Both instances follow the same stimulus table, so bypass, hold and reset priority are checked against two different feedback polynomials.

// File: rtl/spg_pkg.sv
package spg_pkg;

  typedef struct packed {
    logic loadSeed;
    logic step;
    logic bypass;
  } ctrlStrobes_t;

  // Feedback masks for a left-shifting register (bit k set = tap on state[k]).
  function automatic logic [31:0] feedbackMask(input int w);
    case (w)
      8:  return 32'h0000_00B8;
      9:  return 32'h0000_0110;
      10: return 32'h0000_0240;
      11: return 32'h0000_0500;
      12: return 32'h0000_0829;
      13: return 32'h0000_100D;
      14: return 32'h0000_2015;
      15: return 32'h0000_6000;
      16: return 32'h0000_D008;
      17: return 32'h0001_2000;
      18: return 32'h0002_0400;
      19: return 32'h0004_0023;
      20: return 32'h0009_0000;
      21: return 32'h0014_0000;
      22: return 32'h0030_0000;
      23: return 32'h0042_0000;
      default: return 32'h0000_D008;
    endcase
  endfunction

endpackage

// File: rtl/spg_ctrl.sv
module spg_ctrl (
  input  logic                  rst,
  input  logic                  advance,
  input  logic                  bypass,
  output spg_pkg::ctrlStrobes_t strobes
);

  // Reset wins over advance; bypass only steers the output mux.
  always_comb begin
    strobes.loadSeed = rst;
    strobes.step     = advance & ~rst;
    strobes.bypass   = bypass;
  end

endmodule

// File: rtl/spg_datapath.sv
module spg_datapath #(
  parameter int unsigned WIDTH    = 16,
  parameter int unsigned CHANNELS = 24,
  parameter int unsigned SEED     = 32'h0000_ACE1,
  parameter logic [CHANNELS*WIDTH-1:0] TAP_SETS = '0
) (
  input  logic                  clk,
  input  spg_pkg::ctrlStrobes_t strobes,
  output logic [CHANNELS-1:0]   chanOut,
  output logic [WIDTH-1:0]      stateOut
);

  localparam logic [WIDTH-1:0] FB_MASK   = WIDTH'(spg_pkg::feedbackMask(WIDTH));
  localparam logic [WIDTH-1:0] SEED_TRUNC = WIDTH'(SEED);
  localparam logic [WIDTH-1:0] SEED_EFF  = (SEED_TRUNC == '0) ? WIDTH'(1) : SEED_TRUNC;

  logic [WIDTH-1:0] state;
  logic             feedbackBit;

  assign feedbackBit = ^(state & FB_MASK);

  always_ff @(posedge clk) begin
    if (strobes.loadSeed)
      state <= SEED_EFF;
    else if (strobes.step)
      state <= {state[WIDTH-2:0], feedbackBit};
  end

  assign stateOut = state;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    localparam int unsigned BASE  = c % WIDTH;
    localparam int unsigned GROUP = c / WIDTH;
    localparam int unsigned PAIR  = (BASE + 1 + GROUP) % WIDTH;
    localparam logic [WIDTH-1:0] OVERRIDE = TAP_SETS[c*WIDTH +: WIDTH];
    localparam logic [WIDTH-1:0] DEFTAPS  = (WIDTH'(1) << BASE) | (WIDTH'(1) << PAIR);
    localparam logic [WIDTH-1:0] TAPS     = (OVERRIDE != '0) ? OVERRIDE : DEFTAPS;

    logic shifted;
    assign shifted    = ^(state & TAPS);
    assign chanOut[c] = strobes.bypass ? state[BASE] : shifted;
  end

endmodule

// File: rtl/scan_pattern_gen.sv
module scan_pattern_gen #(
  parameter int unsigned WIDTH    = 16,
  parameter int unsigned CHANNELS = 24,
  parameter int unsigned SEED     = 32'h0000_ACE1,
  parameter logic [CHANNELS*WIDTH-1:0] TAP_SETS = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                advance,
  input  logic                bypass,
  output logic [CHANNELS-1:0] chanOut,
  output logic [WIDTH-1:0]    lfsrState
);

  spg_pkg::ctrlStrobes_t strobes;

  spg_ctrl u_ctrl (
    .rst     (rst),
    .advance (advance),
    .bypass  (bypass),
    .strobes (strobes)
  );

  spg_datapath #(
    .WIDTH    (WIDTH),
    .CHANNELS (CHANNELS),
    .SEED     (SEED),
    .TAP_SETS (TAP_SETS)
  ) u_dp (
    .clk      (clk),
    .strobes  (strobes),
    .chanOut  (chanOut),
    .stateOut (lfsrState)
  );

endmodule

// File: rtl/spg_checker.sv
module spg_checker #(
  parameter int unsigned WIDTH    = 16,
  parameter int unsigned CHANNELS = 24,
  parameter int unsigned SEED     = 32'h0000_ACE1
) (
  input logic                clk,
  input logic                rst,
  input logic                advance,
  input logic                bypass,
  input logic [CHANNELS-1:0] chanOut,
  input logic [WIDTH-1:0]    lfsrState
);

  localparam logic [WIDTH-1:0] SEED_T   = WIDTH'(SEED);
  localparam logic [WIDTH-1:0] SEED_EXP = (SEED_T == '0) ? WIDTH'(1) : SEED_T;
  localparam int unsigned LAST_BIT = (CHANNELS - 1) % WIDTH;

  // R1 / R10: first cycle after reset shows the effective seed
  p_seed_load_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> lfsrState == SEED_EXP);

  // R2: an advance moves every bit one place up
  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    advance |=> lfsrState[WIDTH-1:1] == $past(lfsrState[WIDTH-2:0]));

  // R3: no advance, no change
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(lfsrState));

  // R4: dead state is never reached
  p_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    lfsrState != '0);

  // R8: bypass exposes raw bits on first and last channel
  p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
    bypass |-> (chanOut[0] == lfsrState[0]) &&
               (chanOut[CHANNELS-1] == lfsrState[LAST_BIT]));

endmodule

bind scan_pattern_gen spg_checker #(
  .WIDTH    (WIDTH),
  .CHANNELS (CHANNELS),
  .SEED     (SEED)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .advance   (advance),
  .bypass    (bypass),
  .chanOut   (chanOut),
  .lfsrState (lfsrState)
);

// File: tb/sim_scan_pattern_gen.sv
`timescale 1ns/1ps
module sim_scan_pattern_gen;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic advance = 1'b0;
  logic bypass = 1'b0;

  logic [23:0] chan0;
  logic [15:0] st0;
  logic [9:0]  chan1;
  logic [7:0]  st1;

  int nChecks = 0;
  int nFail   = 0;

  always #2.5 clk = ~clk;

  scan_pattern_gen #(.WIDTH(16), .CHANNELS(24), .SEED(32'hACE1)) u0 (
    .clk(clk), .rst(rst), .advance(advance), .bypass(bypass),
    .chanOut(chan0), .lfsrState(st0));

  // channel 9 overridden to taps {7,2,0}
  scan_pattern_gen #(.WIDTH(8), .CHANNELS(10), .SEED(0),
                     .TAP_SETS({8'h85, 72'h0})) u1 (
    .clk(clk), .rst(rst), .advance(advance), .bypass(bypass),
    .chanOut(chan1), .lfsrState(st1));

  function automatic logic [15:0] nxt16(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
  endfunction

  function automatic logic [7:0] nxt8(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic [23:0] exp16(input logic [15:0] s, input logic byp);
    logic [23:0] r;
    for (int c = 0; c < 24; c++) begin
      int b = c % 16;
      int g = c / 16;
      r[c] = byp ? s[b] : (s[b] ^ s[(b + 1 + g) % 16]);
    end
    return r;
  endfunction

  function automatic logic [9:0] exp8(input logic [7:0] s, input logic byp);
    logic [9:0] r;
    for (int c = 0; c < 10; c++) begin
      int b = c % 8;
      int g = c / 8;
      if (byp)         r[c] = s[b];
      else if (c == 9) r[c] = s[0] ^ s[2] ^ s[7];
      else             r[c] = s[b] ^ s[(b + 1 + g) % 8];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, return at the following negedge
  task automatic cyc(input logic r, input logic a, input logic b);
    rst = r; advance = a; bypass = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  // {rst, advance, bypass}
  localparam logic [2:0] STIM [14] = '{
    3'b100, 3'b010, 3'b010, 3'b000, 3'b001, 3'b011, 3'b011,
    3'b000, 3'b110, 3'b010, 3'b011, 3'b001, 3'b010, 3'b100
  };

  initial begin
    #1000000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [15:0] m0;
    logic [7:0]  m1;
    logic [63:0] streams [24];
    int first0, first1, bad2;
    logic zero0, zero1;

    @(negedge clk);
    cyc(1'b1, 1'b0, 1'b0);
    m0 = 16'hACE1;
    m1 = 8'h01;
    chk("R1 seed load", 64'(st0), 64'(m0));
    chk("R1 zero seed replaced", 64'(st1), 64'(m1));

    foreach (STIM[i]) begin
      logic r, a, b;
      string tS, tC;
      {r, a, b} = STIM[i];
      cyc(r, a, b);
      if (r) begin
        m0 = 16'hACE1; m1 = 8'h01;
        tS = a ? "R10 reset over advance" : "R1 reset";
      end else if (a) begin
        m0 = nxt16(m0); m1 = nxt8(m1);
        tS = b ? "R11 bypass keeps stepping" : "R2 step";
      end else begin
        tS = "R3 hold";
      end
      tC = b ? "R8 bypass channels" : "R6 shifted channels";
      chk(tS, 64'(st0), 64'(m0));
      chk(tS, 64'(st1), 64'(m1));
      chk(tC, 64'(chan0), 64'(exp16(st0, b)));
      chk(b ? "R8 bypass channels" : "R7 override channel",
          64'(chan1), 64'(exp8(st1, b)));
    end

    // full-period run
    cyc(1'b1, 1'b0, 1'b0);
    m0 = 16'hACE1;
    first0 = 0; first1 = 0; bad2 = 0;
    zero0 = 1'b0; zero1 = 1'b0;
    for (int i = 1; i <= 65535; i++) begin
      cyc(1'b0, 1'b1, 1'b0);
      m0 = nxt16(m0);
      if (st0 !== m0) bad2++;
      if (st0 == 16'h0) zero0 = 1'b1;
      if (st1 == 8'h0)  zero1 = 1'b1;
      if (first0 == 0 && st0 == 16'hACE1) first0 = i;
      if (first1 == 0 && st1 == 8'h01)    first1 = i;
      if (i <= 64)
        for (int c = 0; c < 24; c++) streams[c][i-1] = chan0[c];
    end
    chk("R2 sequence over full period", 64'(bad2), 64'(0));
    chk("R4 zero never reached (16-bit)", 64'(zero0), 64'(0));
    chk("R4 zero never reached (8-bit)", 64'(zero1), 64'(0));
    chk("R5 period 16-bit", 64'(first0), 64'(65535));
    chk("R5 period 8-bit", 64'(first1), 64'(255));

    begin
      int dup = 0;
      for (int a = 0; a < 24; a++)
        for (int b = a + 1; b < 24; b++)
          if (streams[a] == streams[b]) dup++;
      chk("R9 distinct channel streams", 64'(dup), 64'(0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule